// File: doc/BRIEF.md
# SPI Serial EEPROM Command Sequencer

This block performs single-byte reads and writes on a serial EEPROM that uses 16-bit addresses and the common one-byte opcode command set. A host presents a request (direction, address, and write data) with a one-cycle valid strobe. The block then runs every chip-select frame the operation needs through its own byte-level SPI shifter and answers with a one-cycle done pulse. For a read, the received byte comes back on `rd_data`.

A read takes one frame. A write takes three steps. First a write-enable frame of its own, then the frame that carries the write opcode, address and data, then a series of status polls. Polling stops when the write-in-progress bit clears, or when the poll budget runs out, in which case the error flag is raised. Chip-select setup, hold and idle times are given in nanoseconds, turned into system clocks rounded up, and enforced around every frame. The bus runs in SPI mode 0 by default; a parameter selects mode 3.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk sits at its idle level (0 in mode 0), and busy, done and err are 0.
- R2: A read is one frame of four bytes: 0x03, address bits 15:8, address bits 7:0, and a dummy 0x00. The byte received during the dummy is presented on rd_data in the cycle done is 1.
- R3: A write first sends a one-byte frame holding 0x06 and raises cs_n. It then sends a second frame of four bytes: 0x02, address high byte, address low byte, and the data byte.
- R4: After the data frame, the block repeats two-byte frames (0x05 then 0x00) until bit 0 of the received status byte is 0. A device that reports busy for N polls therefore sees N+1 poll frames.
- R5: cs_n is low for at least ceil(CS_SETUP_NS/CLK_PERIOD_NS) clocks before the first sclk edge of a frame. It stays low at least ceil(CS_HOLD_NS/CLK_PERIOD_NS) clocks after the last sclk edge, and sclk never toggles while cs_n is high.
- R6: cs_n stays high for at least ceil(CS_IDLE_NS/CLK_PERIOD_NS) clocks between any two frames. This covers frames within an operation, consecutive polls, and consecutive operations.
- R7: Bytes are shifted MSB first. In mode 0, sclk idles low, each high phase lasts HALF_CYC clocks, mosi changes only on falling edges, and miso is sampled on rising edges.
- R8: If POLL_LIMIT consecutive polls all return bit 0 = 1, the block ends the write with done = 1 and err = 1. It starts no further frame.
- R9: A request strobe that arrives while busy is 1 is ignored: it causes no frame and no change to the device.
- R10: busy is 1 from the cycle after a request is accepted until the cycle done pulses. done lasts exactly one cycle, and busy is 0 while done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout, valid with done |
| rd_data | output | 8 | Read result, valid with done after a read |
| cs_n | output | 1 | Device chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
A wrong frame type or byte index inside the sequencer shows up at the device pins within one frame. The device model logs it as a malformed frame or returns the wrong data on the next read. A wrong poll counter or status decode changes the number of poll frames the model counts after each write, or raises err in the wrong place, and this is visible when that write's done pulse arrives. A delay counter that is off by one is caught by the pin-level timing monitor at the first chip-select transition it affects.

// File: rtl/eepseq_pkg.sv
package eepseq_pkg;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  typedef enum logic [1:0] {FR_READ, FR_WREN, FR_WRITE, FR_RDSR} frame_e;

  // index of the last byte in a frame
  function automatic logic [1:0] frame_last(frame_e f);
    case (f)
      FR_WREN: return 2'd0;
      FR_RDSR: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [7:0] frame_byte(frame_e f, logic [1:0] i,
                                            logic [15:0] a, logic [7:0] d);
    case (i)
      2'd0: begin
        case (f)
          FR_READ:  return OP_READ;
          FR_WREN:  return OP_WREN;
          FR_WRITE: return OP_WRITE;
          default:  return OP_RDSR;
        endcase
      end
      2'd1:    return (f == FR_RDSR) ? 8'h00 : a[15:8];
      2'd2:    return a[7:0];
      default: return (f == FR_WRITE) ? d : 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/eepseq_shifter.sv
module eepseq_shifter #(
  parameter int HALF_CYC = 2,
  parameter bit CPOL     = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DIV_W-1:0] div;
  logic [3:0]       half;
  logic [7:0]       tx_sh, rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      sclk  <= CPOL;
      mosi  <= 1'b0;
      div   <= '0;
      half  <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      rx    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          sclk  <= 1'b0;
          tx_sh <= tx;
          mosi  <= tx[7];
          div   <= '0;
          half  <= '0;
        end
      end else if (div != DIV_W'(HALF_CYC - 1)) begin
        div <= div + 1'b1;
      end else begin
        div  <= '0;
        half <= half + 1'b1;
        if (!half[0]) begin
          sclk  <= 1'b1;                    // rising edge: sample
          rx_sh <= {rx_sh[6:0], miso};
        end else if (half == 4'd15) begin
          busy <= 1'b0;
          sclk <= CPOL;
          done <= 1'b1;
          rx   <= rx_sh;
        end else begin
          sclk  <= 1'b0;                    // falling edge: next bit out
          tx_sh <= {tx_sh[6:0], 1'b0};
          mosi  <= tx_sh[6];
        end
      end
    end
  end

  // R7: between bytes the clock rests at its idle level
  a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sclk == CPOL));

  // R7: mosi moves only while sclk is low during a byte
  a_r7_mosi_on_low: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mosi)) |-> !sclk);

endmodule

// File: rtl/eepseq_ctrl.sv
module eepseq_ctrl
  import eepseq_pkg::*;
#(
  parameter int SETUP_CYC  = 25,
  parameter int HOLD_CYC   = 25,
  parameter int IDLE_CYC   = 50,
  parameter int POLL_LIMIT = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [7:0]  rd_data,
  output logic        cs_n,
  output logic        x_start,
  output logic [7:0]  x_tx,
  input  logic        x_busy,
  input  logic        x_done,
  input  logic [7:0]  x_rx
);
  localparam int MAX_CYC = (SETUP_CYC > HOLD_CYC) ?
                           ((SETUP_CYC > IDLE_CYC) ? SETUP_CYC : IDLE_CYC) :
                           ((HOLD_CYC > IDLE_CYC) ? HOLD_CYC : IDLE_CYC);
  localparam int CNT_W  = $clog2(MAX_CYC + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_GAP} st_e;

  st_e               st;
  frame_e            frame;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        idx;
  logic [POLL_W-1:0] polls;
  logic [15:0]       addr_q;
  logic [7:0]        wdata_q, last_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      frame   <= FR_READ;
      cnt     <= '0;
      idx     <= '0;
      polls   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      last_rx <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
      cs_n    <= 1'b1;
      x_start <= 1'b0;
      x_tx    <= '0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      x_start <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          busy    <= 1'b1;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          frame   <= req_write ? FR_WREN : FR_READ;
          cs_n    <= 1'b0;
          cnt     <= '0;
          st      <= S_SETUP;
        end
        S_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          x_start <= 1'b1;
          x_tx    <= frame_byte(frame, 2'd0, addr_q, wdata_q);
          idx     <= '0;
          st      <= S_SHIFT;
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (x_done) begin
          if (idx == frame_last(frame)) begin
            last_rx <= x_rx;
            cnt     <= '0;
            st      <= S_HOLD;
          end else begin
            idx     <= idx + 1'b1;
            x_start <= 1'b1;
            x_tx    <= frame_byte(frame, idx + 1'b1, addr_q, wdata_q);
          end
        end
        S_HOLD: if (cnt == CNT_W'(HOLD_CYC - 1)) begin
          cs_n <= 1'b1;
          cnt  <= '0;
          st   <= S_GAP;
        end else cnt <= cnt + 1'b1;
        S_GAP: if (cnt == CNT_W'(IDLE_CYC - 1)) begin
          cnt <= '0;
          case (frame)
            FR_READ: begin
              rd_data <= last_rx;
              done    <= 1'b1;
              busy    <= 1'b0;
              st      <= S_IDLE;
            end
            FR_WREN: begin
              frame <= FR_WRITE;
              cs_n  <= 1'b0;
              st    <= S_SETUP;
            end
            FR_WRITE: begin
              polls <= '0;
              frame <= FR_RDSR;
              cs_n  <= 1'b0;
              st    <= S_SETUP;
            end
            default: begin
              if (!last_rx[0] || polls == POLL_W'(POLL_LIMIT - 1)) begin
                err  <= last_rx[0];
                done <= 1'b1;
                busy <= 1'b0;
                st   <= S_IDLE;
              end else begin
                polls <= polls + 1'b1;
                cs_n  <= 1'b0;
                st    <= S_SETUP;
              end
            end
          endcase
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: no byte is on the wire while the device is deselected
  a_r5_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !x_busy);

  // R10: done is a single-cycle pulse that closes a busy interval
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8: error is only reported with completion
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  a_r8_poll_bound: assert property (@(posedge clk) disable iff (rst)
    polls < POLL_W'(POLL_LIMIT));

  // R9: captured request is frozen while an operation runs
  a_r9_request_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q)));

endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int CS_SETUP_NS   = 250,
  parameter int CS_HOLD_NS    = 250,
  parameter int CS_IDLE_NS    = 500,
  parameter int HALF_CYC      = 2,
  parameter bit MODE3         = 1'b0,
  parameter int POLL_LIMIT    = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [7:0]  rd_data,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int SETUP_RAW = (CS_SETUP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int HOLD_RAW  = (CS_HOLD_NS  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int IDLE_RAW  = (CS_IDLE_NS  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int HOLD_CYC  = (HOLD_RAW  < 1) ? 1 : HOLD_RAW;
  localparam int IDLE_CYC  = (IDLE_RAW  < 1) ? 1 : IDLE_RAW;

  logic       x_start, x_busy, x_done;
  logic [7:0] x_tx, x_rx;

  eepseq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .IDLE_CYC  (IDLE_CYC),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rd_data  (rd_data),
    .cs_n     (cs_n),
    .x_start  (x_start),
    .x_tx     (x_tx),
    .x_busy   (x_busy),
    .x_done   (x_done),
    .x_rx     (x_rx)
  );

  eepseq_shifter #(
    .HALF_CYC(HALF_CYC),
    .CPOL    (MODE3)
  ) u_shift (
    .clk  (clk),
    .rst  (rst),
    .start(x_start),
    .tx   (x_tx),
    .miso (miso),
    .sclk (sclk),
    .mosi (mosi),
    .busy (x_busy),
    .done (x_done),
    .rx   (x_rx)
  );

endmodule

// File: tb/sim_eeprom_cmd_seq.sv
`timescale 1ns/1ps
module sim_eeprom_cmd_seq;
  localparam int SETUP = 25, HOLD = 25, IDLE = 50, HALF = 2, LIMIT = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic busy, done, err, cs_n, sclk, mosi, miso;
  logic [7:0] rd_data;

  always #5 clk = ~clk;

  eeprom_cmd_seq #(.POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM ----------------
  logic [7:0] mem [0:1023];
  logic [7:0] m_sh, m_out, m_op, m_ahi, m_alo, m_wd, m_byte;
  logic [2:0] m_bit = '0;
  int m_nb = 0, wip_cnt = 0, wip_setting = 0;
  bit wel = 0;
  int n_wren = 0, n_write = 0, n_rdsr = 0, n_read = 0, n_bad = 0;
  initial m_out = '0;
  assign miso = cs_n ? 1'b0 : m_out[3'd7 - m_bit];

  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      if (m_bit != 0) n_bad++;
      else if (m_nb == 1 && m_op == 8'h06) begin wel = 1; n_wren++; end
      else if (m_nb == 4 && m_op == 8'h02 && wel) begin
        mem[{m_ahi[1:0], m_alo}] = m_wd; wel = 0; wip_cnt = wip_setting; n_write++;
      end
      else if (m_nb == 2 && m_op == 8'h05) begin
        if (wip_cnt > 0) wip_cnt--; n_rdsr++;
      end
      else if (m_nb == 4 && m_op == 8'h03) n_read++;
      else if (m_nb != 0) n_bad++;
      m_nb = 0; m_bit = 0; m_out = 0;
    end else begin
      m_sh = {m_sh[6:0], mosi};
      if (m_bit == 3'd7) begin
        m_byte = m_sh; m_out = 8'h00;
        case (m_nb)
          0: begin m_op = m_byte; if (m_op == 8'h05) m_out = {7'b0, wip_cnt != 0}; end
          1: m_ahi = m_byte;
          2: begin m_alo = m_byte; if (m_op == 8'h03) m_out = mem[{m_ahi[1:0], m_alo}]; end
          default: m_wd = m_byte;
        endcase
        m_nb++; m_bit = 0;
      end else m_bit = m_bit + 1'b1;
    end
  end

  // ---------------- pin timing monitor (R5, R6, R7) ----------------
  int tcyc = 0, t_fall = 0, t_rise = 0, t_last = 0;
  int v_setup = 0, v_hold = 0, v_idle = 0, v_idle_sck = 0, v_half = 0;
  bit cs_prev = 1, sck_prev = 0, first = 0, have_rise = 0;
  always @(negedge clk) begin
    tcyc++;
    if (!rst) begin
      if (cs_prev && !cs_n) begin
        if (have_rise && tcyc - t_rise < IDLE) v_idle++;
        t_fall = tcyc; first = 1;
      end
      if (!cs_prev && cs_n) begin
        have_rise = 1; t_rise = tcyc;
        if (!first && tcyc - t_last < HOLD) v_hold++;
      end
      if (sclk != sck_prev) begin
        if (cs_n) v_idle_sck++;
        else begin
          if (first && tcyc - t_fall < SETUP) v_setup++;
          first = 0;
          if (!sclk && tcyc - t_last != HALF) v_half++;
          t_last = tcyc;
        end
      end
      if (cs_n && sclk) v_idle_sck++;
    end
    cs_prev = cs_n; sck_prev = sclk;
  end

  // ---------------- host operation ----------------
  logic [7:0] op_rd;
  bit op_err;
  task automatic run_op(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input bit inject, input logic [15:0] ia);
    int k;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1, "R10", "busy after accept", busy, 1);
    if (inject) begin
      repeat (30) @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = ia; req_wdata = 8'hEE;
      @(negedge clk);
      req_valid = 0;
    end
    k = 0;
    while (done !== 1'b1 && k < 20000) begin
      if (busy !== 1'b1) begin
        chk(0, "R10", "busy dropped before done", busy, 1); k = 20000;
      end
      @(negedge clk); k++;
    end
    chk(done === 1'b1, "R10", "done seen", done, 1);
    chk(busy === 1'b0, "R10", "busy low with done", busy, 0);
    op_rd = rd_data; op_err = err;
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(cs_n === 1'b1, "R1", "cs_n reset", cs_n, 1);
    chk(sclk === 1'b0, "R1", "sclk reset", sclk, 0);
    chk(busy === 1'b0, "R1", "busy reset", busy, 0);
    chk(done === 1'b0, "R1", "done reset", done, 0);
    chk(err === 1'b0, "R1", "err reset", err, 0);
  endtask

  task automatic t_write_read_one();
    int w0 = n_wren, wr0 = n_write, r0 = n_rdsr, rd0 = n_read;
    wip_setting = 3;
    run_op(1, 16'h0234, 8'hA5, 0, 0);
    chk(n_wren == w0 + 1, "R3", "write-enable frames", n_wren - w0, 1);
    chk(n_write == wr0 + 1, "R3", "data frames", n_write - wr0, 1);
    chk(n_rdsr == r0 + 4, "R4", "poll frames for 3 busy", n_rdsr - r0, 4);
    chk(op_err == 0, "R4", "no error", op_err, 0);
    run_op(0, 16'h0234, 8'h00, 0, 0);
    chk(n_read == rd0 + 1, "R2", "read frames", n_read - rd0, 1);
    chk(op_rd == 8'hA5, "R2", "read data", op_rd, 8'hA5);
  endtask

  task automatic t_patterns();
    logic [15:0] addrs [8] = '{16'h0000, 16'h00FF, 16'h0100, 16'h1201,
                               16'h2342, 16'h0355, 16'hFFFE, 16'hFFFF};
    for (int p = 0; p < 2; p++) begin
      wip_setting = (p == 0) ? 1 : 0;
      for (int i = 0; i < 8; i++) begin
        int r0 = n_rdsr;
        logic [7:0] v = 8'(i * 8'h11) ^ 8'h5A;
        if (p == 1) v = ~v;
        run_op(1, addrs[i], v, 0, 0);
        chk(n_rdsr == r0 + wip_setting + 1, "R4", "poll count", n_rdsr - r0, wip_setting + 1);
        chk(mem[{addrs[i][9:8], addrs[i][7:0]}] == v, "R3", "device byte", mem[{addrs[i][9:8], addrs[i][7:0]}], v);
      end
      for (int i = 0; i < 8; i++) begin
        logic [7:0] v = 8'(i * 8'h11) ^ 8'h5A;
        if (p == 1) v = ~v;
        run_op(0, addrs[i], 8'h00, 0, 0);
        chk(op_rd == v, "R2", "pattern readback", op_rd, v);
      end
    end
  endtask

  task automatic t_ignore_busy();
    int wr0;
    mem[10'h1C7] = 8'h3C;
    wip_setting = 2;
    wr0 = n_write;
    run_op(1, 16'h0011, 8'h77, 1, 16'h01C7);
    repeat (300) @(negedge clk);
    chk(busy === 1'b0 && cs_n === 1'b1, "R9", "idle after ignored strobe", busy, 0);
    chk(n_write == wr0 + 1, "R9", "one data frame only", n_write - wr0, 1);
    run_op(0, 16'h01C7, 8'h00, 0, 0);
    chk(op_rd == 8'h3C, "R9", "untouched byte", op_rd, 8'h3C);
  endtask

  task automatic t_timeout();
    int r0 = n_rdsr, f0;
    wip_setting = 1000;
    run_op(1, 16'h0042, 8'h99, 0, 0);
    chk(op_err == 1, "R8", "err at timeout", op_err, 1);
    chk(n_rdsr == r0 + LIMIT, "R8", "polls before timeout", n_rdsr - r0, LIMIT);
    f0 = n_rdsr + n_read + n_write + n_wren;
    repeat (400) @(negedge clk);
    chk(n_rdsr + n_read + n_write + n_wren == f0, "R8", "no frame after timeout",
        n_rdsr + n_read + n_write + n_wren - f0, 0);
    chk(cs_n === 1'b1, "R8", "deselected after timeout", cs_n, 1);
    wip_cnt = 0;
  endtask

  task automatic t_timing_summary();
    chk(v_setup == 0, "R5", "setup violations", v_setup, 0);
    chk(v_hold == 0, "R5", "hold violations", v_hold, 0);
    chk(v_idle_sck == 0, "R5", "sclk activity while deselected", v_idle_sck, 0);
    chk(v_idle == 0, "R6", "idle gap violations", v_idle, 0);
    chk(v_half == 0, "R7", "high phase length", v_half, 0);
    chk(n_bad == 0, "R7", "malformed frames", n_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write_read_one();
    t_patterns();
    t_ignore_busy();
    t_timeout();
    t_timing_summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule